// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-slave SPI master that software drives through a small 32-bit register bus. Each bus access takes one cycle: an address, a write strobe with write data, and read data that follows the address combinationally. The bus has no handshake and no back-pressure. A write is always accepted in the cycle it is presented, and the block drops a transmit write that it cannot act on.

Software first sets the clock mode, the word size and the divide ratio in the configuration register. It then asserts the chip select and clears the completion flag. A write to the transmit register launches one full-duplex exchange of 8 or 16 bits. When the exchange ends, the completion flag becomes nonzero and the received word can be read from the receive register. The serial clock is the system clock divided by an even ratio from 4 to 30. The block copies the mode, the size and the ratio when a word starts, so register writes made during a word do not affect that word.

Top module: `spi_regmap_master`

## Requirements
- R1: Register offsets are control 0x00, configuration 0x04, transmit 0x08, receive 0x0C and completion 0x10. After reset every register reads 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: Control bit 0 drives the chip select. Writing 1 drives `spi_cs_n` low and writing 0 drives it high.
- R3: The configuration register implements five fields: bits [4:0] are the prescale code, bit 5 selects 16-bit words (1) or 8-bit words (0), bit 11 is clock polarity and bit 12 is clock phase. Only these bits read back; every other bit reads 0.
- R4: When code bit 4 is 1, the divide ratio is twice code[3:0], and the block uses 4 when that product is less than 4. Each SCLK half period lasts ratio/2 system clocks. The completion flag reads nonzero exactly N*ratio+1 cycles after the cycle of the transmit write, where N is the word length.
- R5: When code bit 4 is 0, SCLK stays at its idle level and the word never completes.
- R6: Data moves MSB first. In 8-bit mode only transmit bits [7:0] are sent, and receive bits [15:8] read 0. In 16-bit mode transmit bits [15:0] are sent.
- R7: SCLK idles at the polarity level. With phase 0, MISO is sampled on the first edge of each bit and MOSI changes on the second edge. With phase 1, MOSI changes on the first edge and MISO is sampled on the second edge.
- R8: Completion sets the completion register to 1. A bus write of 0 to it clears it, and a nonzero write leaves it unchanged.
- R9: If a word completes in the same cycle that software writes 0 to the completion register, the register reads 1 afterwards.
- R10: A transmit write made while a word is in progress is ignored. The word in flight keeps its data and its length.
- R11: A configuration write during a word leaves that word's mode, size and ratio unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
Two events can fall in the same cycle: the engine setting the completion flag and software clearing it with a write of 0. The bench provokes this with the fastest 8-bit setting. Because R4 fixes the completion cycle, the bench can time the clearing write to land on exactly that clock edge. It then judges the result by reading the flag back and expecting 1, which shows the completion was not lost. It also lands a transmit write and a configuration write in the middle of a word, and checks that the word's timing and data are unchanged.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_CFG   = 'h04;
  localparam int OFF_TX    = 'h08;
  localparam int OFF_RX    = 'h0C;
  localparam int OFF_CAUSE = 'h10;

  localparam int POS_WIDE = 5;
  localparam int POS_CPOL = 11;
  localparam int POS_CPHA = 12;
  localparam int CODE_W   = 5;
  localparam int WORD_MAX = 16;

  typedef struct packed {
    logic              cpha;
    logic              cpol;
    logic              wide;
    logic [CODE_W-1:0] code;
  } spi_mode_t;
endpackage

// File: rtl/spi_rm_clkgen.sv
module spi_rm_clkgen
  import spi_rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int HW = CODE_W - 1;

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] half;

  assign half = (code[HW-1:0] < HW'(2)) ? HW'(2) : code[HW-1:0];
  assign tick = busy && code[HW] && (cnt_q == half - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!busy || tick) cnt_q <= '0;
    else if (code[HW]) cnt_q <= cnt_q + HW'(1);
  end

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter
  import spi_rm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  spi_mode_t           mode_live,
  input  logic [WORD_MAX-1:0] tx_word,
  input  logic                tick,
  input  logic                miso,
  output logic                busy,
  output spi_mode_t           mode_lat,
  output logic                sclk,
  output logic                mosi,
  output logic                fin,
  output logic [WORD_MAX-1:0] rx_word
);
  localparam int HALF_W = WORD_MAX / 2;
  localparam int EW     = $clog2(2 * WORD_MAX);

  logic                busy_q, fin_q, sclk_q;
  spi_mode_t           lat_q;
  logic [WORD_MAX-1:0] tx_sh, rx_sh;
  logic [EW-1:0]       ecnt;
  logic [EW-1:0]       last_edge;

  assign last_edge = lat_q.wide ? EW'(2 * WORD_MAX - 1) : EW'(2 * HALF_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      sclk_q <= 1'b0;
      lat_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      ecnt   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= mode_live.cpol;
        if (start) begin
          busy_q <= 1'b1;
          lat_q  <= mode_live;
          tx_sh  <= mode_live.wide ? tx_word : {tx_word[HALF_W-1:0], {HALF_W{1'b0}}};
          rx_sh  <= '0;
          ecnt   <= '0;
        end
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        ecnt   <= ecnt + EW'(1);
        if (ecnt[0] == lat_q.cpha) rx_sh <= {rx_sh[WORD_MAX-2:0], miso};
        else if (ecnt != '0)       tx_sh <= {tx_sh[WORD_MAX-2:0], 1'b0};
        if (ecnt == last_edge) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign mode_lat = lat_q;
  assign sclk     = sclk_q;
  assign mosi     = tx_sh[WORD_MAX-1];
  assign fin      = fin_q;
  assign rx_word  = rx_sh;

  assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ecnt <= last_edge);
  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(lat_q));
  assert_sclk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick |=> $stable(sclk_q));
endmodule

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic                fin,
  input  logic [WORD_MAX-1:0] rx_word,
  output spi_mode_t           mode_live,
  output logic [WORD_MAX-1:0] tx_word,
  output logic                start,
  output logic                cs_on
);
  logic                cs_q, cause_q;
  spi_mode_t           cfg_q;
  logic [WORD_MAX-1:0] tx_q, rx_q;
  logic                hit_ctrl, hit_cfg, hit_tx, hit_cause;

  assign hit_ctrl  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_cfg   = bus_we && (bus_addr == ADDR_W'(OFF_CFG));
  assign hit_tx    = bus_we && (bus_addr == ADDR_W'(OFF_TX));
  assign hit_cause = bus_we && (bus_addr == ADDR_W'(OFF_CAUSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      cause_q <= 1'b0;
      cfg_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      if (hit_ctrl) cs_q <= bus_wdata[0];
      if (hit_cfg) begin
        cfg_q.cpha <= bus_wdata[POS_CPHA];
        cfg_q.cpol <= bus_wdata[POS_CPOL];
        cfg_q.wide <= bus_wdata[POS_WIDE];
        cfg_q.code <= bus_wdata[CODE_W-1:0];
      end
      if (hit_tx && !busy) tx_q <= bus_wdata[WORD_MAX-1:0];
      if (fin) begin
        cause_q <= 1'b1;
        rx_q    <= rx_word;
      end else if (hit_cause && bus_wdata == '0) begin
        cause_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):  bus_rdata[0] = cs_q;
      ADDR_W'(OFF_CFG): begin
        bus_rdata[POS_CPHA]     = cfg_q.cpha;
        bus_rdata[POS_CPOL]     = cfg_q.cpol;
        bus_rdata[POS_WIDE]     = cfg_q.wide;
        bus_rdata[CODE_W-1:0]   = cfg_q.code;
      end
      ADDR_W'(OFF_TX):    bus_rdata[WORD_MAX-1:0] = tx_q;
      ADDR_W'(OFF_RX):    bus_rdata[WORD_MAX-1:0] = rx_q;
      ADDR_W'(OFF_CAUSE): bus_rdata[0] = cause_q;
      default:            bus_rdata = '0;
    endcase
  end

  assign mode_live = cfg_q;
  assign tx_word   = hit_tx ? bus_wdata[WORD_MAX-1:0] : tx_q;
  assign start     = hit_tx;
  assign cs_on     = cs_q;

  assert_done_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> cause_q);
  assert_cs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |=> cs_q == $past(bus_wdata[0]));
endmodule

// File: rtl/spi_regmap_master.sv
module spi_regmap_master
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  spi_mode_t           mode_live, mode_lat;
  logic [WORD_MAX-1:0] tx_word, rx_word;
  logic                start, busy, fin, tick, cs_on;

  spi_rm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .fin(fin),
    .rx_word(rx_word), .mode_live(mode_live), .tx_word(tx_word),
    .start(start), .cs_on(cs_on)
  );

  spi_rm_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .code(mode_lat.code), .tick(tick)
  );

  spi_rm_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_live(mode_live),
    .tx_word(tx_word), .tick(tick), .miso(spi_miso), .busy(busy),
    .mode_lat(mode_lat), .sclk(spi_sclk), .mosi(spi_mosi), .fin(fin),
    .rx_word(rx_word)
  );

  assign spi_cs_n = ~cs_on;
endmodule

// File: tb/spi_regmap_master_test.sv
module spi_regmap_master_test;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TX = 5'h08,
                         A_RX = 5'h0C, A_CAUSE = 5'h10;
  localparam int NV = 6;
  // {cfg[15:0], tx[15:0], slave pattern[15:0]}
  localparam logic [47:0] VECS [NV] = '{
    48'h0012_00A5_003C,
    48'h0833_BEEF_1234,
    48'h1014_5581_FF7E,
    48'h183F_8001_C3A5,
    48'h0031_0F0F_F0F0,
    48'h0815_00C3_0099
  };

  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  int          errs = 0, checks = 0;
  logic        finished = 0;

  logic        s_armed = 0;
  int          s_cpha = 0, s_n = 8, se = 0;
  logic [15:0] s_tx = '0, s_rx = '0;

  always #2.5 clk = ~clk;

  spi_regmap_master uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(s_tx[15]), .spi_cs_n(spi_cs_n)
  );

  always @(spi_sclk) begin
    if (s_armed && !spi_cs_n && se < 2 * s_n) begin
      if ((se % 2) == s_cpha) s_rx = {s_rx[14:0], spi_mosi};
      else if (se != 0) s_tx = {s_tx[14:0], 1'b0};
      se++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  // inject: 0 none, 1 transmit write mid-word, 2 config write mid-word
  task automatic run_word(input logic [15:0] cfg, input logic [15:0] tx,
                          input logic [15:0] pat, input int inject);
    int r, n, k;
    logic [31:0] d;
    s_armed = 0;
    wr(A_CFG, {16'h0, cfg});
    wr(A_CTRL, 32'h1);
    wr(A_CAUSE, 32'h0);
    n = cfg[5] ? 16 : 8;
    r = 2 * int'(cfg[3:0]);
    if (r < 4) r = 4;
    s_n = n; s_cpha = int'(cfg[12]); se = 0; s_rx = '0;
    s_tx = cfg[5] ? pat : {pat[7:0], 8'h00};
    s_armed = 1;
    wr(A_TX, {16'h0, tx});
    bus_addr = A_CAUSE;
    k = 0;
    while (k < 2000) begin
      @(negedge clk); k++;
      if (k == 3 && inject != 0) begin
        bus_we = 1;
        bus_addr = (inject == 1) ? A_TX : A_CFG;
        bus_wdata = (inject == 1) ? 32'h0000_6699 : {16'h0, cfg ^ 16'h0820};
      end else if (k == 4) begin
        bus_we = 0; bus_addr = A_CAUSE;
      end
      #1;
      if (bus_addr == A_CAUSE && bus_rdata != 0) break;
    end
    chk("R4 completion cycle", k, n * r + 1);
    rd(A_RX, d);
    chk("R6 received word", d, cfg[5] ? {16'h0, pat} : {24'h0, pat[7:0]});
    chk("R7 slave captured", {16'h0, s_rx}, cfg[5] ? {16'h0, tx} : {24'h0, tx[7:0]});
    if (inject != 2) chk("R7 sclk idle level", {31'h0, spi_sclk}, {31'h0, cfg[11]});
    s_armed = 0;
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    foreach (VECS[i]) begin end
    rd(A_CTRL, d);  chk("R1 ctrl reset", d, 0);
    rd(A_CFG, d);   chk("R1 cfg reset", d, 0);
    rd(A_TX, d);    chk("R1 tx reset", d, 0);
    rd(A_RX, d);    chk("R1 rx reset", d, 0);
    rd(A_CAUSE, d); chk("R1 cause reset", d, 0);
    chk("R1 cs_n reset", {31'h0, spi_cs_n}, 1);
    chk("R1 sclk reset", {31'h0, spi_sclk}, 0);
    // R2 chip select
    wr(A_CTRL, 32'h1); chk("R2 cs asserted", {31'h0, spi_cs_n}, 0);
    wr(A_CTRL, 32'h0); chk("R2 cs released", {31'h0, spi_cs_n}, 1);
    // R3 field readback
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d); chk("R3 cfg readback", d, 32'h0000_183F);
    // table walk: modes, sizes, ratios (0x11 -> ratio 4)
    for (int i = 0; i < NV; i++)
      run_word(VECS[i][47:32], VECS[i][31:16], VECS[i][15:0], 0);
    // R4 code 0x10 treated as ratio 4
    run_word(16'h0030, 16'hA55A, 16'h5AA5, 0);
    // R10 transmit write while busy ignored
    run_word(16'h0033, 16'hC001, 16'h7E7E, 1);
    rd(A_TX, d); chk("R10 tx register kept", d, 32'h0000_C001);
    // R11 config write mid-word leaves word intact
    run_word(16'h0012, 16'h005A, 16'h00E1, 2);
    // R9 completion collides with clearing write
    wr(A_CFG, 32'h12); wr(A_CTRL, 1); wr(A_CAUSE, 0);
    s_armed = 0;
    wr(A_TX, 32'h11);
    repeat (32) @(negedge clk);
    bus_addr = A_CAUSE; bus_wdata = 0; bus_we = 1;
    @(negedge clk); bus_we = 0;
    rd(A_CAUSE, d); chk("R9 flag survives same-cycle clear", d, 1);
    // R8 clear semantics
    wr(A_CAUSE, 32'h5); rd(A_CAUSE, d); chk("R8 nonzero write keeps flag", d, 1);
    wr(A_CAUSE, 32'h0); rd(A_CAUSE, d); chk("R8 zero write clears flag", d, 0);
    // R5 divider disabled
    wr(A_CFG, 32'h0A); wr(A_TX, 32'hFF);
    repeat (200) @(negedge clk);
    rd(A_CAUSE, d); chk("R5 no completion", d, 0);
    chk("R5 sclk held idle", {31'h0, spi_sclk}, 0);
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk("R1 cs_n after reset", {31'h0, spi_cs_n}, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule